// File: doc/BRIEF.md
# Immediate-Operand Test Instruction Sequencer

This block sits beside the decode stage of a small pipelined processor and runs self-test instructions that the assembler places in the slots a hazard would otherwise fill with no-operations. A test instruction carries its own test data as immediate bits. The processor behaves as it would for a no-operation, except that one of its combinational units sees the test operands for one cycle. That unit's response is folded into a parallel signature register. Four test instructions exist. Two of them fit in one word and exercise the control unit and the branch unit. The other two take a second word and exercise the 16-bit adder and the 16-bit ALU.

For the two-word forms the block holds decode for one slot while it collects the second word. It then rebuilds two 16-bit operands from 28 packed bits that share a 4-bit overlap. The control-unit and branch-unit results share one signature register, and the adder and ALU results share the other. Because only one unit is under test in any cycle, a shared register never has two inputs at once. Each captured result is also written into a slice of a pipe register outside the block. The slice is read back one cycle later and compared with the value written, and a mismatch raises a sticky error flag.

Top module: `imm_test_sequencer`

## Requirements
- R1: After reset, both signatures are zero and `stall`, `test_sel`, `slice_we` and `reg_err` are all low.
- R2: The opcode is `instr_word[15:12]`. 0xC tests the control unit, 0xD the branch unit, 0xE the adder and 0xF the ALU. `test_sel` bit 0/1/2/3 selects control/branch/adder/ALU. Exactly one bit is high, for one cycle: the cycle after the instruction's last word is accepted.
- R3: After an accepted first word with opcode 0xE or 0xF, `stall` is high from the next cycle until the second word is accepted. Cycles without `instr_valid` do not end the wait. The second word is taken as data whatever its upper bits are. `stall` is low during the apply cycle.
- R4: For a single-word test, operand A is `{4'b0, word[11:0]}` and operand B is zero.
- R5: For a two-word test, the packed data is `{first[11:0], second[15:0]}`. Operand A is packed bits [15:0] and operand B is packed bits [27:12], so packed bits [15:12] appear in both.
- R6: Control and branch results update `sig_ctl`, and adder and ALU results update `sig_dp`. The update happens at the edge that ends the apply cycle, as s' = (s<<1) ^ (s[15] ? 16'h1021 : 0) ^ result. The other signature is unchanged.
- R7: A word with any other opcode, accepted outside the second-word wait, is ignored. No unit is selected, no stall is raised and neither signature changes.
- R8: In the cycle after an apply cycle, `slice_we` is high and `slice_wd` carries the captured result. `slice_we` is low in every other cycle.
- R9: One cycle after a slice write, `slice_q` is compared with the value written. A difference sets `reg_err`, which stays high until `err_clr` is asserted.
- R10: A new word is accepted during an apply cycle, so consecutive single-word tests apply in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | A fetched word is presented this cycle |
| instr_word | input | 16 | Fetched instruction or immediate word |
| stall | output | 1 | Hold decode of the next instruction |
| test_sel | output | 4 | One-hot unit-under-test select during the apply cycle |
| opnd_a | output | 16 | Test operand A (zero outside the apply cycle) |
| opnd_b | output | 16 | Test operand B (zero outside the apply cycle) |
| cu_res | input | 16 | Control-unit response |
| br_res | input | 16 | Branch-unit response |
| add_res | input | 16 | Adder response |
| alu_res | input | 16 | ALU response |
| slice_we | output | 1 | Write strobe for the pipe-register slice |
| slice_wd | output | 16 | Captured result written to the slice |
| slice_q | input | 16 | Current contents of the slice |
| err_clr | input | 1 | Clears the sticky error flag |
| reg_err | output | 1 | Sticky slice-compare mismatch flag |
| sig_ctl | output | 16 | Signature of control and branch results |
| sig_dp | output | 16 | Signature of adder and ALU results |

## Verification
The bench aims at the operand overlap. Bits placed in the wrong half, or an overlap window shifted by one nibble, would show up as wrong `opnd_a`/`opnd_b` on two-word tests. It feeds a second word whose top nibble looks like a test opcode; a design that decoded it would start a new test and lose the operands. Idle cycles inside the second-word wait would wrongly end the stall in a design that counted cycles instead of words. Back-to-back single-word tests expose a design that adds a bubble after each apply. A corrupted slice write followed by clean traffic shows whether the error flag is really sticky and clears only on request. Long mixed runs drive the signature feedback bit, so a wrong polynomial or routing a result to the other signature would diverge from the bench model.

// File: rtl/tis_seq_pkg.sv
`timescale 1ns/1ps
package tis_seq_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_CTL = 4'hC;
  localparam logic [OPC_W-1:0] OPC_BR  = 4'hD;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'hE;
  localparam logic [OPC_W-1:0] OPC_ALU = 4'hF;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT2 = 2'd1,
    ST_APPLY = 2'd2
  } fetch_st_e;

  typedef enum logic [1:0] {
    U_CTL = 2'd0,
    U_BR  = 2'd1,
    U_ADD = 2'd2,
    U_ALU = 2'd3
  } unit_e;

  function automatic logic opc_is_test(input logic [OPC_W-1:0] opc);
    return (opc == OPC_CTL) || (opc == OPC_BR) || (opc == OPC_ADD) || (opc == OPC_ALU);
  endfunction

  function automatic logic opc_two_word(input logic [OPC_W-1:0] opc);
    return (opc == OPC_ADD) || (opc == OPC_ALU);
  endfunction

  function automatic unit_e opc_unit(input logic [OPC_W-1:0] opc);
    unit_e u;
    case (opc)
      OPC_BR:  u = U_BR;
      OPC_ADD: u = U_ADD;
      OPC_ALU: u = U_ALU;
      default: u = U_CTL;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/tis_rst_sync.sv
`timescale 1ns/1ps
module tis_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = chain_q[STAGES-1];

endmodule

// File: rtl/tis_fetch_fsm.sv
`timescale 1ns/1ps
module tis_fetch_fsm
  import tis_seq_pkg::*;
#(
  parameter int DW  = 16,
  parameter int OPW = OPC_W,
  parameter int NU  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [DW-1:0] instr_word,
  output logic          stall,
  output logic          apply,
  output unit_e         unit,
  output logic [NU-1:0] sel,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);

  localparam int FW1  = DW - OPW;   // immediate bits in the first word
  localparam int PK_W = FW1 + DW;   // packed test data bits
  localparam int OVL  = 2*DW - PK_W; // bits shared by both operands

  fetch_st_e st_q, st_n;
  unit_e     unit_q, unit_n;
  logic [FW1-1:0]  hi_q, hi_n;
  logic [DW-1:0]   a_q, a_n, b_q, b_n;
  logic            hi_en, op_en, unit_en;

  logic [OPW-1:0]  opc;
  logic [PK_W-1:0] packed_data;

  assign opc         = instr_word[DW-1 -: OPW];
  assign packed_data = {hi_q, instr_word};

  // next-state and datapath enables
  always_comb begin
    st_n    = st_q;
    unit_n  = unit_q;
    hi_n    = hi_q;
    a_n     = a_q;
    b_n     = b_q;
    hi_en   = 1'b0;
    op_en   = 1'b0;
    unit_en = 1'b0;
    case (st_q)
      ST_WAIT2: begin
        if (instr_valid) begin
          a_n   = packed_data[DW-1:0];
          b_n   = packed_data[PK_W-1 -: DW];
          op_en = 1'b1;
          st_n  = ST_APPLY;
        end
      end
      default: begin
        st_n = ST_IDLE;
        if (instr_valid && opc_is_test(opc)) begin
          unit_n  = opc_unit(opc);
          unit_en = 1'b1;
          if (opc_two_word(opc)) begin
            hi_n  = instr_word[FW1-1:0];
            hi_en = 1'b1;
            st_n  = ST_WAIT2;
          end else begin
            a_n   = {{OPW{1'b0}}, instr_word[FW1-1:0]};
            b_n   = '0;
            op_en = 1'b1;
            st_n  = ST_APPLY;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      unit_q <= U_CTL;
      hi_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      st_q <= st_n;
      if (unit_en) unit_q <= unit_n;
      if (hi_en)   hi_q   <= hi_n;
      if (op_en) begin
        a_q <= a_n;
        b_q <= b_n;
      end
    end
  end

  assign stall  = (st_q == ST_WAIT2);
  assign apply  = (st_q == ST_APPLY);
  assign unit   = unit_q;
  assign sel    = apply ? (NU'(1) << unit_q) : '0;
  assign opnd_a = apply ? a_q : '0;
  assign opnd_b = apply ? b_q : '0;

  // R3: a first word of a two-word test raises the stall next cycle
  a_r3_first_word_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !stall && opc_two_word(opc)) |=> stall)
    else $error("two-word opcode did not stall decode");

  // R2: a unit is only selected after a word was consumed
  a_r2_sel_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel) |-> $past(instr_valid))
    else $error("unit selected without a consumed word");

  // R3: stall never overlaps an apply cycle
  a_r3_no_stall_in_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel) |-> !stall)
    else $error("stall high while applying");

  initial begin
    if (OVL != OPW) $error("operand overlap width mismatch");
  end

endmodule

// File: rtl/tis_sig_misr.sv
`timescale 1ns/1ps
module tis_sig_misr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);

  logic [W-1:0] sig_q, sig_n;

  always_comb begin
    sig_n = {sig_q[W-2:0], 1'b0} ^ din;
    if (sig_q[W-1]) sig_n = sig_n ^ POLY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sig_q <= '0;
    else if (en) sig_q <= sig_n;
  end

  assign sig = sig_q;

  // R6: the signature only moves when its unit group is applied
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sig))
    else $error("signature changed without capture");

endmodule

// File: rtl/tis_slice_check.sv
`timescale 1ns/1ps
module tis_slice_check #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_val,
  input  logic [DW-1:0] slice_q,
  input  logic          err_clr,
  output logic          slice_we,
  output logic [DW-1:0] slice_wd,
  output logic          err
);

  logic          we_q, chk_q, err_q, err_n, mismatch;
  logic [DW-1:0] wd_q, exp_q;

  assign mismatch = chk_q && (|(slice_q ^ exp_q));

  always_comb begin
    err_n = (err_q && !err_clr) || mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      chk_q <= 1'b0;
      err_q <= 1'b0;
      wd_q  <= '0;
      exp_q <= '0;
    end else begin
      we_q  <= cap_en;
      chk_q <= we_q;
      err_q <= err_n;
      if (cap_en) wd_q  <= cap_val;
      if (we_q)   exp_q <= wd_q;
    end
  end

  assign slice_we = we_q;
  assign slice_wd = wd_q;
  assign err      = err_q;

  // R8: every capture is followed by a slice write
  a_r8_write_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> slice_we)
    else $error("capture without slice write");

  // R9: error flag is sticky until cleared
  a_r9_sticky_error: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err)
    else $error("error flag dropped without clear");

endmodule

// File: rtl/imm_test_sequencer.sv
`timescale 1ns/1ps
module imm_test_sequencer
  import tis_seq_pkg::*;
#(
  parameter int        DW        = 16,
  parameter int        RST_STG   = 2,
  parameter logic [15:0] POLY    = 16'h1021
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [DW-1:0] instr_word,
  output logic          stall,
  output logic [3:0]    test_sel,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] cu_res,
  input  logic [DW-1:0] br_res,
  input  logic [DW-1:0] add_res,
  input  logic [DW-1:0] alu_res,
  output logic          slice_we,
  output logic [DW-1:0] slice_wd,
  input  logic [DW-1:0] slice_q,
  input  logic          err_clr,
  output logic          reg_err,
  output logic [DW-1:0] sig_ctl,
  output logic [DW-1:0] sig_dp
);

  localparam int NU    = 4;
  localparam int NMISR = 2;

  logic   rst_s_n;
  logic   apply;
  unit_e  unit;
  logic [DW-1:0] res_sel;
  logic [NMISR-1:0]         m_en;
  logic [NMISR-1:0][DW-1:0] m_sig;

  tis_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  tis_fetch_fsm #(.DW(DW), .OPW(OPC_W), .NU(NU)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .stall       (stall),
    .apply       (apply),
    .unit        (unit),
    .sel         (test_sel),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b)
  );

  // route the unit under test to the capture path
  always_comb begin
    case (unit)
      U_BR:    res_sel = br_res;
      U_ADD:   res_sel = add_res;
      U_ALU:   res_sel = alu_res;
      default: res_sel = cu_res;
    endcase
  end

  // group 0: control/branch, group 1: adder/ALU
  assign m_en[0] = apply && ((unit == U_CTL) || (unit == U_BR));
  assign m_en[1] = apply && ((unit == U_ADD) || (unit == U_ALU));

  for (genvar g = 0; g < NMISR; g++) begin : g_misr
    tis_sig_misr #(.W(DW), .POLY(POLY[DW-1:0])) u_misr (
      .clk   (clk),
      .rst_n (rst_s_n),
      .en    (m_en[g]),
      .din   (res_sel),
      .sig   (m_sig[g])
    );
  end

  assign sig_ctl = m_sig[0];
  assign sig_dp  = m_sig[1];

  tis_slice_check #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cap_en   (apply),
    .cap_val  (res_sel),
    .slice_q  (slice_q),
    .err_clr  (err_clr),
    .slice_we (slice_we),
    .slice_wd (slice_wd),
    .err      (reg_err)
  );

  // R6: a control/branch test leaves the datapath signature alone
  a_r6_ctl_keeps_dp: assert property (@(posedge clk) disable iff (!rst_s_n)
    (test_sel[0] || test_sel[1]) |=> $stable(sig_dp))
    else $error("datapath signature moved on control test");

  // R8: the slice write carries the value captured in the apply cycle
  a_r8_write_value: assert property (@(posedge clk) disable iff (!rst_s_n)
    apply |=> (slice_wd == $past(res_sel)))
    else $error("slice write data differs from captured result");

endmodule

// File: tb/tb_imm_test_sequencer.sv
`timescale 1ns/1ps
module tb_imm_test_sequencer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr_word;
  logic        stall;
  logic [3:0]  test_sel;
  logic [15:0] opnd_a, opnd_b;
  logic [15:0] cu_res, br_res, add_res, alu_res;
  logic        slice_we;
  logic [15:0] slice_wd, slice_q, bad_mask;
  logic        err_clr, reg_err;
  logic [15:0] sig_ctl, sig_dp;

  always #2 clk = ~clk;

  imm_test_sequencer dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .stall(stall), .test_sel(test_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .cu_res(cu_res), .br_res(br_res), .add_res(add_res), .alu_res(alu_res),
    .slice_we(slice_we), .slice_wd(slice_wd), .slice_q(slice_q),
    .err_clr(err_clr), .reg_err(reg_err), .sig_ctl(sig_ctl), .sig_dp(sig_dp)
  );

  // models of the units under test
  function automatic logic [15:0] unit_fn(input logic [3:0] s, input logic [15:0] a, input logic [15:0] b);
    case (s)
      4'b0001: return a ^ 16'h5A3C;
      4'b0010: return {a[7:0], a[15:8]};
      4'b0100: return a + b;
      default: return a ^ ~b;
    endcase
  endfunction

  assign cu_res  = unit_fn(4'b0001, opnd_a, opnd_b);
  assign br_res  = unit_fn(4'b0010, opnd_a, opnd_b);
  assign add_res = unit_fn(4'b0100, opnd_a, opnd_b);
  assign alu_res = unit_fn(4'b1000, opnd_a, opnd_b);

  // model of the pipe-register slice, with optional corruption
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        slice_q <= '0;
    else if (slice_we) slice_q <= slice_wd ^ bad_mask;
  end

  int n_chk = 0;
  int n_bad = 0;
  int n_apply = 0;
  bit mon_en = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] misr_step(input logic [15:0] s, input logic [15:0] r);
    return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000) ^ r;
  endfunction

  function automatic logic [3:0] sel_of(input logic [3:0] op);
    case (op)
      4'hC: return 4'b0001;
      4'hD: return 4'b0010;
      4'hE: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  typedef struct {
    logic [3:0]  sel;
    logic [15:0] a;
    logic [15:0] b;
    bit          two;
  } exp_t;

  exp_t        q[$];
  logic [15:0] m_ctl = '0, m_dp = '0;
  bit          we_chk = 0;
  logic [15:0] we_exp = '0;

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en) begin
      chk(sig_ctl == m_ctl && sig_dp == m_dp, "R6 signatures", {sig_ctl, sig_dp}, {m_ctl, m_dp});
      if (we_chk)
        chk(slice_we && slice_wd == we_exp, "R8 slice write", {15'b0, slice_we, slice_wd}, {16'h0001, we_exp});
      else if (slice_we)
        chk(1'b0, "R8 unexpected slice write", {16'b0, slice_wd}, 32'h0);
      we_chk = 0;
      if (test_sel != 4'b0) begin
        exp_t e;
        logic [15:0] r;
        n_apply++;
        chk(!stall, "R3 stall low in apply", {31'b0, stall}, 32'h0);
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected apply", {28'b0, test_sel}, 32'h0);
        end else begin
          e = q.pop_front();
          chk(test_sel == e.sel, "R2 unit select", {28'b0, test_sel}, {28'b0, e.sel});
          chk(opnd_a == e.a && opnd_b == e.b, e.two ? "R5 packed operands" : "R4 single operands",
              {opnd_a, opnd_b}, {e.a, e.b});
          r = unit_fn(e.sel, e.a, e.b);
          if (e.sel[0] || e.sel[1]) m_ctl = misr_step(m_ctl, r);
          else                      m_dp  = misr_step(m_dp, r);
          we_chk = 1;
          we_exp = r;
        end
      end
    end
  end

  // driver
  task automatic put(input logic [15:0] w);
    @(posedge clk); #1;
    instr_valid = 1'b1;
    instr_word  = w;
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      instr_valid = 1'b0;
      instr_word  = 16'h0000;
    end
  endtask

  task automatic t_single(input logic [3:0] op, input logic [11:0] d);
    exp_t e;
    e.sel = sel_of(op); e.a = {4'b0, d}; e.b = 16'h0000; e.two = 0;
    q.push_back(e);
    put({op, d});
  endtask

  task automatic t_double(input logic [3:0] op, input logic [11:0] hi, input logic [15:0] lo, input int wt);
    exp_t e;
    logic [27:0] pk;
    pk = {hi, lo};
    e.sel = sel_of(op); e.a = pk[15:0]; e.b = pk[27:12]; e.two = 1;
    q.push_back(e);
    put({op, hi});
    if (wt > 0) begin
      gap(wt);
      @(negedge clk);
      chk(stall, "R3 stall held over idle cycles", {31'b0, stall}, 32'h1);
    end
    put(lo);
    @(negedge clk);
    chk(stall, "R3 stall while second word presented", {31'b0, stall}, 32'h1);
  endtask

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin : main
    int c0;
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; err_clr = 1'b0; bad_mask = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(sig_ctl == 16'h0 && sig_dp == 16'h0, "R1 signatures", {sig_ctl, sig_dp}, 32'h0);
    chk(!stall, "R1 stall", {31'b0, stall}, 32'h0);
    chk(test_sel == 4'b0, "R1 select", {28'b0, test_sel}, 32'h0);
    chk(!slice_we, "R1 slice write", {31'b0, slice_we}, 32'h0);
    chk(!reg_err, "R1 error flag", {31'b0, reg_err}, 32'h0);
    mon_en = 1;

    // single-word tests (R2, R4)
    t_single(4'hC, 12'hABC);
    t_single(4'hD, 12'h123);
    gap(2);

    // two-word tests, back to back and with idle cycles (R3, R5)
    t_double(4'hE, 12'h9F1, 16'h2345, 0);
    t_double(4'hF, 12'h0FF, 16'hF00F, 2);
    // second word that looks like a test opcode is plain data (R3)
    t_double(4'hE, 12'h001, 16'hC123, 0);
    t_single(4'hD, 12'hFFF);
    gap(3);

    // R10: consecutive single-word tests without bubbles
    c0 = n_apply;
    t_single(4'hC, 12'h111);
    t_single(4'hD, 12'h222);
    t_single(4'hC, 12'h333);
    gap(1);
    @(negedge clk); #1;
    chk(n_apply - c0 == 3, "R10 no bubble", n_apply - c0, 32'd3);
    gap(2);

    // R7: non-test opcodes ignored
    put(16'h1234);
    put(16'h7FFF);
    gap(1);
    @(negedge clk);
    chk(!stall, "R7 no stall on non-test word", {31'b0, stall}, 32'h0);
    gap(2);
    chk(q.size() == 0, "R7 nothing pending", q.size(), 32'h0);

    // R9: slice compare and sticky error
    @(negedge clk);
    chk(!reg_err, "R9 no error on clean writes", {31'b0, reg_err}, 32'h0);
    bad_mask = 16'h0100;
    t_single(4'hD, 12'h5A5);
    gap(4);
    bad_mask = 16'h0000;
    gap(3);
    @(negedge clk);
    chk(reg_err, "R9 error raised on mismatch", {31'b0, reg_err}, 32'h1);
    t_double(4'hF, 12'h321, 16'h8765, 0);
    gap(4);
    @(negedge clk);
    chk(reg_err, "R9 error stays set", {31'b0, reg_err}, 32'h1);
    @(posedge clk); #1 err_clr = 1'b1;
    @(posedge clk); #1 err_clr = 1'b0;
    @(negedge clk);
    chk(!reg_err, "R9 error cleared", {31'b0, reg_err}, 32'h0);

    // mixed run to drive signature feedback (R6)
    for (int i = 0; i < 24; i++) begin
      case (i % 4)
        0: t_single(4'hC, 12'(i * 341 + 7));
        1: t_double(4'hE, 12'(i * 977 + 3), 16'(i * 40503 + 11), i % 3);
        2: t_single(4'hD, 12'(i * 1291));
        default: t_double(4'hF, 12'(i * 613), 16'(i * 7919 + 5), 0);
      endcase
    end
    gap(6);
    chk(q.size() == 0, "R2 every test applied", q.size(), 32'h0);
    chk(!reg_err, "R9 no error after clean run", {31'b0, reg_err}, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule